// File: doc/BRIEF.md
# Adapter Command and Interrupt-Status Core

This block is the control core that a host talks to when it drives a network adapter. The host writes 16-bit command words into a single port. Each word carries a 5-bit opcode in bits 15..11 and an 11-bit argument in bits 10..0. From these commands the core keeps its state:

- the current register-window number;
- an interrupt-enable mask and a status-visibility mask;
- the receive-filter bits;
- three threshold values;
- the receive and transmit enables.

Hardware event pulses from the rest of the adapter set eight latched cause bits. An acknowledge command clears chosen cause bits.

The host reads a 16-bit status word. It shows the window number, a command-in-progress flag and the visible cause bits. A timer holds the command-in-progress flag high after each accepted command. Commands written while the flag is high are dropped. Reset-type commands keep the flag high for a parameterised wait, so software polls the flag before it issues the next command.

Top module: `adapter_cmd_core`

## Requirements
- R1: After `rst`, all of the following are zero: `status_word`, `irq`, `rx_enable`, `tx_enable`, `rx_filter` and the three thresholds. The status-visibility mask resets to 8'hFF and the interrupt-enable mask resets to 8'h00.
- R2: Opcode 1 loads argument bits 2..0 as the window number. `status_word[15:13]` shows it from the next cycle. `status_word[11:8]` always reads zero.
- R3: A write is accepted when `cmd_valid` is high and `status_word[12]` is low. After an accepted write, `status_word[12]` is high for RESET_WAIT cycles if the opcode was 0, 5 or 0x0B. For any other opcode it is high for exactly one cycle. Writes made while it is high have no effect.
- R4: `hw_event[k]` for k = 1..7 sets cause bit k on the next edge. `hw_event[0]` is ignored. Opcode 0x0C sets cause bit 6. The cause bits are: 0 interrupt latch, 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested, 7 update statistics.
- R5: Opcode 0x0D clears every cause bit whose matching bit in argument bits 7..0 is one. A set and a clear of the same bit on the same edge leave that bit set.
- R6: `irq` is high exactly when the latched causes ANDed with the interrupt-enable mask are nonzero. Opcode 0x0E loads that mask from argument bits 7..0. While `irq` is high, cause bit 0 is set on the next edge.
- R7: `status_word[7:0]` equals the latched causes ANDed with the status-visibility mask. Opcode 0x0F loads that mask from argument bits 7..0.
- R8: Opcode 0x10 loads `rx_filter` from argument bits 3..0. The bits are: 0 individual, 1 multicast, 2 broadcast, 3 promiscuous.
- R9: Opcodes 0x11, 0x12 and 0x13 load argument bits 10..0 into `rx_early_thresh`, `tx_avail_thresh` and `tx_start_thresh`.
- R10: Opcode 3 clears `rx_enable` and opcode 4 sets it. Opcode 0x0A clears `tx_enable` and opcode 9 sets it. Opcode 5 clears `rx_enable` and opcode 0x0B clears `tx_enable`, each with the long busy wait.
- R11: Opcode 0 returns every register to its R1 value, including the cause bits. Hardware events on that same edge are discarded. It then starts the long busy wait.
- R12: Any opcode not listed in R2 to R11 changes no register. It only raises the one-cycle busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Opcode in bits 15..11, argument in bits 10..0 |
| hw_event | input | 8 | Per-cause set pulses from the adapter; bit 0 unused |
| status_word | output | 16 | Window, command-in-progress flag, visible causes |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receiver enable |
| tx_enable | output | 1 | Transmitter enable |
| rx_filter | output | 4 | Receive filter bits |
| rx_early_thresh | output | 11 | RX early threshold |
| tx_avail_thresh | output | 11 | TX available threshold |
| tx_start_thresh | output | 11 | TX start threshold |

## Verification
Directed sequences come first. They place an acknowledge on the same edge as a matching event, which separates set-wins from clear-wins ordering. They write right behind an accepted command and during the long reset wait, which shows whether busy writes are dropped. They send hw_event bit 0 alone and unlisted opcodes with nonzero arguments, which shows whether ignored inputs leak into state. After that, a seeded random stream of opcodes, arguments and sparse event pulses runs. It mixes mask loads with acknowledges, so mask gating, latch setting and busy timing are all compared every cycle against a reference model in the bench.

// File: rtl/adcmd_pkg.sv
`timescale 1ns/1ps
package adcmd_pkg;

    localparam int CMD_W   = 16;
    localparam int OP_W    = 5;
    localparam int ARG_W   = 11;
    localparam int CAUSE_W = 8;
    localparam int WIN_W   = 3;
    localparam int FILT_W  = 4;
    localparam int NUM_THR = 3;

    localparam int CAUSE_LATCH = 0;
    localparam int CAUSE_REQ   = 6;

    typedef enum logic [OP_W-1:0] {
        OP_GLOBAL_RESET = 5'h00,
        OP_WINDOW       = 5'h01,
        OP_RX_OFF       = 5'h03,
        OP_RX_ON        = 5'h04,
        OP_RX_RESET     = 5'h05,
        OP_TX_ON        = 5'h09,
        OP_TX_OFF       = 5'h0A,
        OP_TX_RESET     = 5'h0B,
        OP_REQ_INT      = 5'h0C,
        OP_ACK          = 5'h0D,
        OP_INT_MASK     = 5'h0E,
        OP_VIS_MASK     = 5'h0F,
        OP_FILTER       = 5'h10,
        OP_THR_RXEARLY  = 5'h11,
        OP_THR_TXAVAIL  = 5'h12,
        OP_THR_TXSTART  = 5'h13
    } opcode_e;

    typedef struct packed {
        logic               global_rst;
        logic               long_wait;
        logic               win_ld;
        logic               rx_off;
        logic               rx_on;
        logic               tx_off;
        logic               tx_on;
        logic               req_int;
        logic               ack;
        logic               imask_ld;
        logic               vmask_ld;
        logic               filt_ld;
        logic [NUM_THR-1:0] thr_ld;
    } cmd_act_t;

    function automatic logic [OP_W-1:0] opcode_of(input logic [CMD_W-1:0] w);
        return w[CMD_W-1 -: OP_W];
    endfunction

    function automatic logic [ARG_W-1:0] arg_of(input logic [CMD_W-1:0] w);
        return w[ARG_W-1:0];
    endfunction

endpackage

// File: rtl/adcmd_decode.sv
`timescale 1ns/1ps
module adcmd_decode
    import adcmd_pkg::*;
(
    input  logic            accept,
    input  logic [OP_W-1:0] opcode,
    output cmd_act_t        act
);

    always_comb begin
        act = '0;
        if (accept) begin
            case (opcode)
                OP_GLOBAL_RESET: begin
                    act.global_rst = 1'b1;
                    act.long_wait  = 1'b1;
                end
                OP_WINDOW:      act.win_ld = 1'b1;
                OP_RX_OFF:      act.rx_off = 1'b1;
                OP_RX_ON:       act.rx_on  = 1'b1;
                OP_RX_RESET: begin
                    act.rx_off    = 1'b1;
                    act.long_wait = 1'b1;
                end
                OP_TX_ON:       act.tx_on  = 1'b1;
                OP_TX_OFF:      act.tx_off = 1'b1;
                OP_TX_RESET: begin
                    act.tx_off    = 1'b1;
                    act.long_wait = 1'b1;
                end
                OP_REQ_INT:     act.req_int  = 1'b1;
                OP_ACK:         act.ack      = 1'b1;
                OP_INT_MASK:    act.imask_ld = 1'b1;
                OP_VIS_MASK:    act.vmask_ld = 1'b1;
                OP_FILTER:      act.filt_ld  = 1'b1;
                OP_THR_RXEARLY: act.thr_ld   = 3'b001;
                OP_THR_TXAVAIL: act.thr_ld   = 3'b010;
                OP_THR_TXSTART: act.thr_ld   = 3'b100;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adcmd_busy_timer.sv
`timescale 1ns/1ps
module adcmd_busy_timer #(
    parameter int RESET_WAIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_wait,
    output logic busy
);

    localparam int CW = $clog2(RESET_WAIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= long_wait ? CW'(RESET_WAIT) : CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = |cnt_q;

endmodule

// File: rtl/adcmd_cause_bank.sv
`timescale 1ns/1ps
module adcmd_cause_bank
    import adcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_all,
    input  logic [CAUSE_W-1:0] hw_set,
    input  logic               req_int,
    input  logic [CAUSE_W-1:0] ack_clr,
    input  logic [CAUSE_W-1:0] int_mask,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               irq
);

    localparam logic [CAUSE_W-1:0] HW_MASK = ~(CAUSE_W'(1) << CAUSE_LATCH);

    logic [CAUSE_W-1:0] set_vec;

    assign irq = |(cause_q & int_mask);

    always_comb begin
        set_vec              = hw_set & HW_MASK;
        set_vec[CAUSE_REQ]   = set_vec[CAUSE_REQ] | req_int;
        set_vec[CAUSE_LATCH] = irq;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~ack_clr) | set_vec;
        end
    end

endmodule

// File: rtl/adapter_cmd_core.sv
`timescale 1ns/1ps
module adapter_cmd_core
    import adcmd_pkg::*;
#(
    parameter int RESET_WAIT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic [CAUSE_W-1:0] hw_event,
    output logic [CMD_W-1:0]   status_word,
    output logic               irq,
    output logic               rx_enable,
    output logic               tx_enable,
    output logic [FILT_W-1:0]  rx_filter,
    output logic [ARG_W-1:0]   rx_early_thresh,
    output logic [ARG_W-1:0]   tx_avail_thresh,
    output logic [ARG_W-1:0]   tx_start_thresh
);

    localparam logic [CAUSE_W-1:0] VMASK_RST = '1;
    localparam logic [CAUSE_W-1:0] IMASK_RST = '0;

    logic               busy;
    logic               accept;
    cmd_act_t           act;
    logic [ARG_W-1:0]   arg;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] imask_q;
    logic [CAUSE_W-1:0] vmask_q;
    logic [WIN_W-1:0]   win_q;
    logic [FILT_W-1:0]  filt_q;
    logic               rx_q;
    logic               tx_q;
    logic [ARG_W-1:0]   thr_q [NUM_THR];

    assign accept = cmd_valid & ~busy;
    assign arg    = arg_of(cmd_word);

    adcmd_decode u_decode (
        .accept (accept),
        .opcode (opcode_of(cmd_word)),
        .act    (act)
    );

    adcmd_busy_timer #(.RESET_WAIT(RESET_WAIT)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .long_wait (act.long_wait),
        .busy      (busy)
    );

    adcmd_cause_bank u_causes (
        .clk       (clk),
        .rst       (rst),
        .clear_all (act.global_rst),
        .hw_set    (hw_event),
        .req_int   (act.req_int),
        .ack_clr   (act.ack ? arg[CAUSE_W-1:0] : '0),
        .int_mask  (imask_q),
        .cause_q   (cause_q),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || act.global_rst) begin
            win_q   <= '0;
            imask_q <= IMASK_RST;
            vmask_q <= VMASK_RST;
            filt_q  <= '0;
            rx_q    <= 1'b0;
            tx_q    <= 1'b0;
        end else begin
            if (act.win_ld)   win_q   <= arg[WIN_W-1:0];
            if (act.imask_ld) imask_q <= arg[CAUSE_W-1:0];
            if (act.vmask_ld) vmask_q <= arg[CAUSE_W-1:0];
            if (act.filt_ld)  filt_q  <= arg[FILT_W-1:0];
            if (act.rx_off)       rx_q <= 1'b0;
            else if (act.rx_on)   rx_q <= 1'b1;
            if (act.tx_off)       tx_q <= 1'b0;
            else if (act.tx_on)   tx_q <= 1'b1;
        end
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst || act.global_rst) begin
                thr_q[t] <= '0;
            end else if (act.thr_ld[t]) begin
                thr_q[t] <= arg;
            end
        end
    end

    assign status_word     = {win_q, busy, 4'b0000, cause_q & vmask_q};
    assign rx_enable       = rx_q;
    assign tx_enable       = tx_q;
    assign rx_filter       = filt_q;
    assign rx_early_thresh = thr_q[0];
    assign tx_avail_thresh = thr_q[1];
    assign tx_start_thresh = thr_q[2];

endmodule

// File: rtl/adcmd_checker.sv
`timescale 1ns/1ps
module adcmd_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [7:0]  hw_event,
    input logic [15:0] status_word,
    input logic        irq,
    input logic        rx_enable,
    input logic        tx_enable,
    input logic [7:0]  cause_q
);

    logic       acc;
    logic [4:0] op;

    assign acc = cmd_valid && !status_word[12];
    assign op  = cmd_word[15:11];

    a_r2_window_load: assert property (@(posedge clk) disable iff (rst)
        acc && op == 5'h01 |=> status_word[15:13] == $past(cmd_word[2:0]));

    a_r3_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        acc |=> status_word[12]);

    a_r3_busy_drops_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && status_word[12] |=>
            $stable(status_word[15:13]) && $stable(rx_enable) && $stable(tx_enable));

    a_r6_latch_follows_irq: assert property (@(posedge clk) disable iff (rst)
        irq && !(acc && op == 5'h00) |=> cause_q[0]);

    a_r5_ack_all: assert property (@(posedge clk) disable iff (rst)
        acc && op == 5'h0D && cmd_word[7:0] == 8'hFF &&
        (hw_event & 8'hFE) == 8'h00 && !irq |=> cause_q == 8'h00);

    a_r11_global_reset: assert property (@(posedge clk) disable iff (rst)
        acc && op == 5'h00 |=> status_word[15:13] == 3'd0 && !rx_enable &&
            !tx_enable && status_word[12] && cause_q == 8'h00);

    a_r10_rx_on: assert property (@(posedge clk) disable iff (rst)
        acc && op == 5'h04 |=> rx_enable);

endmodule

bind adapter_cmd_core adcmd_checker i_adcmd_checker (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .hw_event    (hw_event),
    .status_word (status_word),
    .irq         (irq),
    .rx_enable   (rx_enable),
    .tx_enable   (tx_enable),
    .cause_q     (cause_q)
);

// File: tb/test_adapter_cmd_core.sv
`timescale 1ns/1ps
module test_adapter_cmd_core;

    localparam int WAIT = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic [7:0]  hw_event;
    logic [15:0] status_word;
    logic        irq;
    logic        rx_enable;
    logic        tx_enable;
    logic [3:0]  rx_filter;
    logic [10:0] rx_early_thresh;
    logic [10:0] tx_avail_thresh;
    logic [10:0] tx_start_thresh;

    adapter_cmd_core #(.RESET_WAIT(WAIT)) i_adapter_cmd_core (
        .clk             (clk),
        .rst             (rst),
        .cmd_valid       (cmd_valid),
        .cmd_word        (cmd_word),
        .hw_event        (hw_event),
        .status_word     (status_word),
        .irq             (irq),
        .rx_enable       (rx_enable),
        .tx_enable       (tx_enable),
        .rx_filter       (rx_filter),
        .rx_early_thresh (rx_early_thresh),
        .tx_avail_thresh (tx_avail_thresh),
        .tx_start_thresh (tx_start_thresh)
    );

    always #10 clk = ~clk;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    bit    m_ok   = 0;
    string ctx    = "R1";

    logic [2:0]  m_win;
    int          m_cnt;
    logic [7:0]  m_cause, m_imask, m_vmask;
    logic [3:0]  m_filt;
    logic [10:0] m_thr0, m_thr1, m_thr2;
    logic        m_rx, m_tx;

    function automatic logic [15:0] cmd(input logic [4:0] op, input logic [10:0] a);
        return {op, a};
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", ctx, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 window",          {13'd0, status_word[15:13]}, {13'd0, m_win});
        check("R3 busy flag",       {15'd0, status_word[12]}, {15'd0, m_cnt != 0});
        check("R2 zero bits",       {12'd0, status_word[11:8]}, 16'd0);
        check("R7 visible causes",  {8'd0, status_word[7:0]}, {8'd0, m_cause & m_vmask});
        check("R6 irq",             {15'd0, irq}, {15'd0, |(m_cause & m_imask)});
        check("R10 rx_enable",      {15'd0, rx_enable}, {15'd0, m_rx});
        check("R10 tx_enable",      {15'd0, tx_enable}, {15'd0, m_tx});
        check("R8 filter",          {12'd0, rx_filter}, {12'd0, m_filt});
        check("R9 rx early",        {5'd0, rx_early_thresh}, {5'd0, m_thr0});
        check("R9 tx avail",        {5'd0, tx_avail_thresh}, {5'd0, m_thr1});
        check("R9 tx start",        {5'd0, tx_start_thresh}, {5'd0, m_thr2});
    endtask

    task automatic model_reset(input int cnt);
        m_win = 0; m_cnt = cnt; m_cause = 0; m_imask = 8'h00; m_vmask = 8'hFF;
        m_filt = 0; m_thr0 = 0; m_thr1 = 0; m_thr2 = 0; m_rx = 0; m_tx = 0;
    endtask

    task automatic step(input logic r, input logic v, input logic [15:0] w, input logic [7:0] e);
        logic       acc, irq_m;
        logic [4:0] op;
        logic [10:0] a;
        logic [7:0] setv, ackv;
        @(negedge clk);
        if (m_ok) compare_all();
        rst = r; cmd_valid = v; cmd_word = w; hw_event = e;
        @(posedge clk);
        #1;
        acc = v && (m_cnt == 0);
        op = w[15:11];
        a = w[10:0];
        irq_m = |(m_cause & m_imask);
        if (r) begin
            model_reset(0);
            m_ok = 1;
        end else if (acc && op == 5'h00) begin
            model_reset(WAIT);
        end else begin
            setv = {e[7], e[6] | (acc && op == 5'h0C), e[5:1], irq_m};
            ackv = (acc && op == 5'h0D) ? a[7:0] : 8'h00;
            m_cause = (m_cause & ~ackv) | setv;
            if (acc) m_cnt = (op == 5'h05 || op == 5'h0B) ? WAIT : 1;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            if (acc) begin
                case (op)
                    5'h01: m_win = a[2:0];
                    5'h03, 5'h05: m_rx = 0;
                    5'h04: m_rx = 1;
                    5'h09: m_tx = 1;
                    5'h0A, 5'h0B: m_tx = 0;
                    5'h0E: m_imask = a[7:0];
                    5'h0F: m_vmask = a[7:0];
                    5'h10: m_filt = a[3:0];
                    5'h11: m_thr0 = a;
                    5'h12: m_thr1 = a;
                    5'h13: m_thr2 = a;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'h0000, 8'h00);
    endtask

    task automatic send(input logic [4:0] op, input logic [10:0] a);
        step(0, 1, cmd(op, a), 8'h00);
        idle(1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cmd_valid = 0; cmd_word = 0; hw_event = 0;
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        ctx = "R1";
        idle(2);
        @(negedge clk);
        check("R1 status at reset", status_word, 16'h0000);

        ctx = "R2";
        send(5'h01, 11'h7F5);
        send(5'h01, 11'h002);

        ctx = "R3";
        step(0, 1, cmd(5'h01, 11'h006), 8'h00);
        step(0, 1, cmd(5'h01, 11'h001), 8'h00);
        idle(1);
        @(negedge clk);
        check("R3 busy write dropped", {13'd0, status_word[15:13]}, 16'd6);

        ctx = "R4";
        step(0, 0, 0, 8'h01);
        idle(1);
        @(negedge clk);
        check("R4 event bit0 ignored", {8'd0, status_word[7:0]}, 16'h0000);
        step(0, 0, 0, 8'h24);
        send(5'h0C, 11'h000);
        @(negedge clk);
        check("R4 causes set", {8'd0, status_word[7:0]}, 16'h0064);

        ctx = "R5";
        send(5'h0D, 11'h004);
        step(0, 1, cmd(5'h0D, 11'h060), 8'h20);
        idle(1);
        @(negedge clk);
        check("R5 set beats clear", {8'd0, status_word[7:0]}, 16'h0020);

        ctx = "R6";
        send(5'h0E, 11'h020);
        idle(2);
        ctx = "R7";
        send(5'h0F, 11'h00E);
        send(5'h0F, 11'h0FF);
        send(5'h0D, 11'h0FF);
        send(5'h0E, 11'h000);
        send(5'h0D, 11'h0FF);

        ctx = "R8";
        send(5'h10, 11'h7FA);
        ctx = "R9";
        send(5'h11, 11'h5A5);
        send(5'h12, 11'h7FF);
        send(5'h13, 11'h001);
        ctx = "R10";
        send(5'h04, 11'h000);
        send(5'h09, 11'h000);
        send(5'h03, 11'h000);
        send(5'h04, 11'h000);
        step(0, 1, cmd(5'h05, 11'h000), 8'h00);
        idle(WAIT + 1);
        step(0, 1, cmd(5'h0B, 11'h000), 8'h00);
        idle(WAIT + 1);

        ctx = "R12";
        send(5'h02, 11'h7FF);
        send(5'h06, 11'h0FF);
        send(5'h08, 11'h3FF);
        send(5'h14, 11'h7FF);
        send(5'h1F, 11'h7FF);
        @(negedge clk);
        check("R12 filter kept", {12'd0, rx_filter}, 16'h000A);

        ctx = "R11";
        send(5'h04, 11'h000);
        step(0, 1, cmd(5'h00, 11'h000), 8'hFE);
        step(0, 1, cmd(5'h04, 11'h000), 8'h00);
        idle(WAIT + 1);
        @(negedge clk);
        check("R11 rx after reset", {15'd0, rx_enable}, 16'h0000);

        ctx = "random";
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  op;
            logic [10:0] a;
            logic [7:0]  ev;
            int          pick;
            pick = $urandom_range(0, 99);
            if (pick < 2)       op = 5'h00;
            else if (pick < 6)  op = ($urandom_range(0, 1) != 0) ? 5'h05 : 5'h0B;
            else                op = 5'($urandom_range(1, 31));
            a  = 11'($urandom());
            ev = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h00;
            step(0, $urandom_range(0, 2) == 0, cmd(op, a), ev);
        end
        idle(1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule